// File: doc/BRIEF.md
# Second-Level Cache Control Register

This block holds the 32-bit supervisor control word of an external second-level cache and turns several of its fields into live hardware controls. Software reads and writes the whole word through a single-cycle special-register port. The stored fields drive the cache's enable, write-through, data-side-only and instruction-side-only modes. A lock indication is derived from the two side-only bits. The parity enable field gates a parity vector so that zeros go out while parity is disabled.

Two fields start companion engines. The global invalidate bit and the hardware flush bit each raise a request toward their engine. Hardware clears each bit once the engine reports completion, and software cannot clear it. A sequencer state machine with the states `ES_IDLE`, `ES_INV` and `ES_FLUSH` serves one request at a time and gives invalidate priority. The transitions are: `ES_IDLE`→`ES_INV` when the invalidate bit is pending, `ES_IDLE`→`ES_FLUSH` when only the flush bit is pending, and `ES_INV`/`ES_FLUSH`→`ES_IDLE` on the matching done pulse.

A second state machine has the states `PW_RUN` and `PW_LOW`. It moves `PW_RUN`→`PW_LOW` when the core signals nap or sleep, and moves back `PW_LOW`→`PW_RUN` when both are clear. While it is in `PW_LOW` it asserts the cache RAM low-power pin if the ZZ control bit is set, and stops the cache clock if the clock-stop bit is set. The least significant bit of the read word mirrors the invalidate engine's busy line.

Top module: `cache_cfg_reg`

## Requirements

Bit positions below use the port vector index, where index 31 is the most significant bit. The fields and their indices are:

| Index | Field |
|---|---|
| 31 | enable |
| 30 | parity enable |
| 29:28 | size |
| 27:25 | clock ratio |
| 24:23 | RAM type |
| 22 | data-only |
| 21 | global invalidate |
| 20 | ZZ control |
| 19 | write-through |
| 18 | test support |
| 17:16 | output hold |
| 15 | DLL slow |
| 14 | differential clock |
| 13 | DLL bypass |
| 12 | flush assist |
| 11 | hardware flush |
| 10 | instruction-only |
| 9 | clock stop |
| 8 | DLL rollover |
| 7:1 | reserved |
| 0 | invalidate in progress |

- R1: While `rst_n` is low, and after it is released, every stored field is zero and the error flag is zero. `cache_en`, `inv_req`, `flush_req`, `ram_zz` and `par_out` are 0, and `ram_clk_en` is 1.
- R2: Index 0 of `rd_data` always equals `inv_busy`. Indices 7:1 always read 0. A write stores indices 31:8 as given, subject to R3, R4, R5 and R8.
- R3: A write setting index 21 while the stored enable is 0 sets the bit. Two clock edges after the write, `inv_req` rises. The bit and `inv_req` clear on the edge where `inv_done` is high while the request is active.
- R4: A write setting index 21 while the stored enable is 1 leaves index 21 unchanged, while all other fields of that write take effect.
- R5: A write while the stored enable is 1 leaves index 19 (write-through) unchanged.
- R6: `cfg_err` becomes 1 after any write that sets index 21 while enable is 1, and stays 1 until reset.
- R7: Index 11 (hardware flush) raises `flush_req` and is cleared by hardware on the edge where `flush_done` is high during the flush request. When both index 21 and index 11 are pending, the invalidate request is served first. The two requests are never high together.
- R8: Software cannot clear index 21 or index 11: a write with a 0 there leaves a pending bit set.
- R9: `dside_only` equals index 22 and `iside_only` equals index 10. `alloc_lock` is 1 exactly when both are set.
- R10: One edge after `core_nap` or `core_sleep` rises, `ram_zz` equals index 20 and `ram_clk_en` equals the inverse of index 9. One edge after both are low, `ram_zz` is 0 and `ram_clk_en` is 1.
- R11: `par_out` equals `par_in` when index 30 is 1, and is all zeros when index 30 is 0.
- R12: `cache_en` takes the stored enable bit only on an edge where `txn_accept` is high, and holds otherwise.
- R13: `wt_mode` equals the stored index 19.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| wr_en | input | 1 | Write strobe of the register port |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Current register value |
| txn_accept | input | 1 | A cache transaction is accepted this cycle |
| inv_busy | input | 1 | Invalidate engine busy |
| inv_done | input | 1 | Invalidate engine completion pulse |
| flush_done | input | 1 | Flush engine completion pulse |
| core_nap | input | 1 | Core is in nap |
| core_sleep | input | 1 | Core is in sleep |
| par_in | input | PAR_W | Generated parity before gating |
| inv_req | output | 1 | Global invalidate request |
| flush_req | output | 1 | Hardware flush request |
| cache_en | output | 1 | Enable applied to transactions |
| wt_mode | output | 1 | Write-through mode |
| dside_only | output | 1 | Data-side-only allocation |
| iside_only | output | 1 | Instruction-side-only allocation |
| alloc_lock | output | 1 | No new allocations |
| ram_zz | output | 1 | Cache RAM low-power pin |
| ram_clk_en | output | 1 | Cache clock running |
| par_out | output | PAR_W | Gated parity |
| cfg_err | output | 1 | Sticky illegal-invalidate error |

## Verification

The bench builds the block with its default parity width of 8, so the gating check covers every lane of one byte's parity. The field layout itself has no parameter: the full 32-bit word, the self-clearing bits and both state machines are reached at that single setting. The directed phase drives the invalidate and flush handshakes, their priority and the power transitions. A seeded random phase then mixes writes, transaction accepts and busy levels, so that the enable-dependent write filtering meets every prior register state.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int REG_W  = 32;

    // Vector index of each field (index 31 is the most significant bit).
    localparam int P_EN    = 31;
    localparam int P_PE    = 30;
    localparam int P_DO    = 22;
    localparam int P_INV   = 21;
    localparam int P_ZZ    = 20;
    localparam int P_WT    = 19;
    localparam int P_HWF   = 11;
    localparam int P_IO    = 10;
    localparam int P_CSTOP = 9;
    localparam int RSV_HI  = 7;
    localparam int RSV_LO  = 1;
    localparam int P_IP    = 0;

    function automatic logic [REG_W-1:0] writable_mask();
        logic [REG_W-1:0] m;
        m = '1;
        for (int i = RSV_LO; i <= RSV_HI; i++) begin
            m[i] = 1'b0;
        end
        m[P_IP] = 1'b0;
        return m;
    endfunction

    localparam logic [REG_W-1:0] WR_MASK = writable_mask();

    typedef enum logic [1:0] {
        ES_IDLE  = 2'd0,
        ES_INV   = 2'd1,
        ES_FLUSH = 2'd2
    } eng_state_t;

    typedef enum logic {
        PW_RUN = 1'b0,
        PW_LOW = 1'b1
    } pwr_state_t;

endpackage

// File: rtl/ccr_field_store.sv
module ccr_field_store
    import ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             inv_clr,
    input  logic             hwf_clr,
    output logic [REG_W-1:0] cfg_q,
    output logic             err_q
);

    logic [REG_W-1:0] cfg_d;
    logic             err_d;
    logic             en_now;
    logic             inv_base;
    logic             hwf_base;

    assign en_now = cfg_q[P_EN];

    always_comb begin
        inv_base = cfg_q[P_INV] & ~inv_clr;
        hwf_base = cfg_q[P_HWF] & ~hwf_clr;
        cfg_d    = cfg_q;
        if (wr_en) begin
            cfg_d = wr_data & WR_MASK;
            if (en_now) begin
                cfg_d[P_WT] = cfg_q[P_WT];
            end
            cfg_d[P_INV] = inv_base | (wr_data[P_INV] & ~en_now);
            cfg_d[P_HWF] = hwf_base | wr_data[P_HWF];
        end else begin
            cfg_d[P_INV] = inv_base;
            cfg_d[P_HWF] = hwf_base;
        end
        err_d = err_q | (wr_en & en_now & wr_data[P_INV]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            err_q <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            err_q <= err_d;
        end
    end

    // R4: invalidate request refused while enabled
    a_r4_inv_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_q[P_EN] && wr_data[P_INV] && !cfg_q[P_INV]) |=> !cfg_q[P_INV]);

    // R5: write-through frozen while enabled
    a_r5_wt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_q[P_EN]) |=> (cfg_q[P_WT] == $past(cfg_q[P_WT])));

    // R6: error flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R8: a pending flush bit survives a write unless the engine finishes
    a_r8_hwf_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[P_HWF] && !hwf_clr) |=> cfg_q[P_HWF]);

endmodule

// File: rtl/ccr_engine_seq.sv
module ccr_engine_seq
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inv_pend,
    input  logic hwf_pend,
    input  logic inv_done,
    input  logic flush_done,
    output logic inv_req,
    output logic flush_req,
    output logic inv_clr,
    output logic hwf_clr
);

    eng_state_t state_q;
    eng_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ES_IDLE: begin
                if (inv_pend) begin
                    state_d = ES_INV;
                end else if (hwf_pend) begin
                    state_d = ES_FLUSH;
                end
            end
            ES_INV: begin
                if (inv_done) begin
                    state_d = ES_IDLE;
                end
            end
            ES_FLUSH: begin
                if (flush_done) begin
                    state_d = ES_IDLE;
                end
            end
            default: state_d = ES_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ES_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        inv_req   = 1'b0;
        flush_req = 1'b0;
        inv_clr   = 1'b0;
        hwf_clr   = 1'b0;
        unique case (state_q)
            ES_IDLE: ;
            ES_INV: begin
                inv_req = 1'b1;
                inv_clr = inv_done;
            end
            ES_FLUSH: begin
                flush_req = 1'b1;
                hwf_clr   = flush_done;
            end
            default: ;
        endcase
    end

    // R7: one request at a time
    a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inv_req, flush_req}));

    // R7: flush done ends the request and the pending bit
    a_r7_flush_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_done) |=> (!flush_req && !hwf_pend));

    // R3: invalidate done ends the request and the pending bit
    a_r3_inv_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && inv_done) |=> (!inv_req && !inv_pend));

endmodule

// File: rtl/ccr_power_ctl.sv
module ccr_power_ctl
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_nap,
    input  logic core_sleep,
    input  logic zz_ctl,
    input  logic stop_ctl,
    output logic ram_zz,
    output logic ram_clk_en
);

    pwr_state_t state_q;
    pwr_state_t state_d;
    logic       low_req;

    assign low_req = core_nap | core_sleep;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_RUN: if (low_req)  state_d = PW_LOW;
            PW_LOW: if (!low_req) state_d = PW_RUN;
            default: state_d = PW_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PW_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ram_zz     = 1'b0;
        ram_clk_en = 1'b1;
        unique case (state_q)
            PW_RUN: ;
            PW_LOW: begin
                ram_zz     = zz_ctl;
                ram_clk_en = ~stop_ctl;
            end
            default: ;
        endcase
    end

    // R10: leaving nap and sleep releases both controls
    a_r10_exit_release: assert property (@(posedge clk) disable iff (!rst_n)
        !low_req |=> (!ram_zz && ram_clk_en));

endmodule

// File: rtl/cache_cfg_reg.sv
module cache_cfg_reg
    import ccr_pkg::*;
#(
    parameter int PAR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic             txn_accept,
    input  logic             inv_busy,
    input  logic             inv_done,
    input  logic             flush_done,
    input  logic             core_nap,
    input  logic             core_sleep,
    input  logic [PAR_W-1:0] par_in,
    output logic             inv_req,
    output logic             flush_req,
    output logic             cache_en,
    output logic             wt_mode,
    output logic             dside_only,
    output logic             iside_only,
    output logic             alloc_lock,
    output logic             ram_zz,
    output logic             ram_clk_en,
    output logic [PAR_W-1:0] par_out,
    output logic             cfg_err
);

    logic [REG_W-1:0] cfg_q;
    logic             inv_clr;
    logic             hwf_clr;
    logic             en_applied_q;

    ccr_field_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .inv_clr (inv_clr),
        .hwf_clr (hwf_clr),
        .cfg_q   (cfg_q),
        .err_q   (cfg_err)
    );

    ccr_engine_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .inv_pend   (cfg_q[P_INV]),
        .hwf_pend   (cfg_q[P_HWF]),
        .inv_done   (inv_done),
        .flush_done (flush_done),
        .inv_req    (inv_req),
        .flush_req  (flush_req),
        .inv_clr    (inv_clr),
        .hwf_clr    (hwf_clr)
    );

    ccr_power_ctl u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_nap   (core_nap),
        .core_sleep (core_sleep),
        .zz_ctl     (cfg_q[P_ZZ]),
        .stop_ctl   (cfg_q[P_CSTOP]),
        .ram_zz     (ram_zz),
        .ram_clk_en (ram_clk_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_applied_q <= 1'b0;
        end else if (txn_accept) begin
            en_applied_q <= cfg_q[P_EN];
        end
    end

    genvar g;
    generate
        for (g = 0; g < PAR_W; g++) begin : g_par
            assign par_out[g] = par_in[g] & cfg_q[P_PE];
        end
    endgenerate

    always_comb begin
        rd_data       = cfg_q;
        rd_data[P_IP] = inv_busy;
    end

    assign cache_en   = en_applied_q;
    assign wt_mode    = cfg_q[P_WT];
    assign dside_only = cfg_q[P_DO];
    assign iside_only = cfg_q[P_IO];
    assign alloc_lock = cfg_q[P_DO] & cfg_q[P_IO];

    // R12: applied enable only moves on an accepted transaction
    a_r12_en_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_accept |=> $stable(cache_en));

endmodule

// File: tb/sim_cache_cfg_reg.sv
module sim_cache_cfg_reg;

    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          txn_accept = 1'b0;
    logic          inv_busy = 1'b0;
    logic          inv_done = 1'b0;
    logic          flush_done = 1'b0;
    logic          core_nap = 1'b0;
    logic          core_sleep = 1'b0;
    logic [PW-1:0] par_in = '0;
    logic          inv_req, flush_req, cache_en, wt_mode;
    logic          dside_only, iside_only, alloc_lock;
    logic          ram_zz, ram_clk_en, cfg_err;
    logic [PW-1:0] par_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cache_cfg_reg #(.PAR_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .txn_accept(txn_accept), .inv_busy(inv_busy),
        .inv_done(inv_done), .flush_done(flush_done), .core_nap(core_nap),
        .core_sleep(core_sleep), .par_in(par_in), .inv_req(inv_req),
        .flush_req(flush_req), .cache_en(cache_en), .wt_mode(wt_mode),
        .dside_only(dside_only), .iside_only(iside_only),
        .alloc_lock(alloc_lock), .ram_zz(ram_zz), .ram_clk_en(ram_clk_en),
        .par_out(par_out), .cfg_err(cfg_err)
    );

    localparam logic [31:0] B_EN = 32'h8000_0000, B_PE = 32'h4000_0000;
    localparam logic [31:0] B_DO = 32'h0040_0000, B_INV = 32'h0020_0000;
    localparam logic [31:0] B_ZZ = 32'h0010_0000, B_WT = 32'h0008_0000;
    localparam logic [31:0] B_HWF = 32'h0000_0800, B_IO = 32'h0000_0400;
    localparam logic [31:0] B_CS = 32'h0000_0200, WMSK = 32'hFFFF_FF00;

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] v);
        wr_en = 1'b1;
        wr_data = v;
        tick();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    // Next register value from the requirements (R2, R4, R5, R8)
    function automatic logic [31:0] model_wr(input logic [31:0] cur, input logic [31:0] d);
        logic [31:0] n;
        n = d & WMSK;
        if (cur[31]) n[19] = cur[19];
        n[21] = cur[21] | (d[21] & ~cur[31]);
        n[11] = cur[11] | d[11];
        return n;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] m_reg;
        logic        m_err, m_en;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_data == 32'h0, "R1 rd", rd_data, 0);
        chk(!cache_en && !inv_req && !flush_req && !ram_zz && ram_clk_en && !cfg_err,
            "R1 outs", {cache_en, inv_req, flush_req, ram_zz, ram_clk_en, cfg_err}, 32'h2);
        rst_n = 1'b1;
        tick();
        chk(rd_data == 32'h0 && par_out == '0, "R1 after release", rd_data, 0);

        // R3 / R7 invalidate and flush with priority
        wr(B_INV | B_HWF);
        chk(rd_data == (B_INV | B_HWF), "R3 bits set", rd_data, B_INV | B_HWF);
        chk(!inv_req, "R3 req not yet", inv_req, 0);
        tick();
        chk(inv_req && !flush_req, "R7 invalidate first", {inv_req, flush_req}, 2);
        wr(32'h0);
        chk(rd_data == (B_INV | B_HWF), "R8 no sw clear", rd_data, B_INV | B_HWF);
        inv_done = 1'b1;
        tick();
        inv_done = 1'b0;
        chk(rd_data == B_HWF && !inv_req, "R3 done clears", rd_data, B_HWF);
        tick();
        chk(flush_req && !inv_req, "R7 flush req", {inv_req, flush_req}, 1);
        flush_done = 1'b1;
        tick();
        flush_done = 1'b0;
        chk(rd_data == 0 && !flush_req, "R7 flush done", rd_data, 0);

        // R4 / R6 / R12
        wr(B_EN);
        chk(cache_en == 1'b0, "R12 no txn yet", cache_en, 0);
        wr(B_EN | B_INV | B_ZZ);
        chk(rd_data == (B_EN | B_ZZ), "R4 inv ignored", rd_data, B_EN | B_ZZ);
        chk(cfg_err, "R6 err set", cfg_err, 1);
        tick();
        chk(!inv_req, "R4 no request", inv_req, 0);
        txn_accept = 1'b1;
        tick();
        txn_accept = 1'b0;
        chk(cache_en, "R12 applied", cache_en, 1);

        // R5 / R13
        wr(B_EN | B_WT);
        chk(!wt_mode && rd_data == B_EN, "R5 wt frozen", rd_data, B_EN);
        wr(32'h0);
        wr(B_WT);
        chk(wt_mode, "R13 wt on", wt_mode, 1);
        chk(cfg_err && cache_en, "R6 sticky / R12 hold", {cfg_err, cache_en}, 3);

        // R10 power
        wr(B_ZZ | B_CS);
        core_nap = 1'b1;
        tick();
        chk(ram_zz && !ram_clk_en, "R10 nap", {ram_zz, ram_clk_en}, 2);
        core_nap = 1'b0;
        core_sleep = 1'b1;
        tick();
        chk(ram_zz && !ram_clk_en, "R10 sleep", {ram_zz, ram_clk_en}, 2);
        core_sleep = 1'b0;
        tick();
        chk(!ram_zz && ram_clk_en, "R10 exit", {ram_zz, ram_clk_en}, 1);
        wr(32'h0);
        core_nap = 1'b1;
        tick();
        chk(!ram_zz && ram_clk_en, "R10 ctl off", {ram_zz, ram_clk_en}, 1);
        core_nap = 1'b0;

        // R11 parity
        par_in = 8'hA5;
        #0;
        chk(par_out == 8'h00, "R11 gated", par_out, 0);
        wr(B_PE);
        chk(par_out == 8'hA5, "R11 pass", par_out, 32'hA5);

        // R9 lock
        wr(B_DO | B_IO);
        chk(alloc_lock && dside_only && iside_only, "R9 lock", alloc_lock, 1);
        wr(B_DO);
        chk(!alloc_lock && dside_only && !iside_only, "R9 unlock", alloc_lock, 0);

        // R2 layout, reserved, busy mirror
        inv_busy = 1'b1;
        wr(32'hFFDF_F7FF);
        chk(rd_data == 32'hFFDF_F701, "R2 layout", rd_data, 32'hFFDF_F701);
        inv_busy = 1'b0;
        #0;
        chk(rd_data[0] == 1'b0, "R2 busy mirror", rd_data, 32'hFFDF_F700);

        // random phase against model
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        m_reg = '0;
        m_err = 1'b0;
        m_en = 1'b0;
        for (int i = 0; i < 400; i++) begin
            logic        w, t;
            logic [31:0] d;
            w = ($urandom % 3) == 0;
            t = ($urandom % 4) == 0;
            d = $urandom;
            inv_busy = $urandom % 2;
            wr_en = w;
            wr_data = d;
            txn_accept = t;
            tick();
            if (t) m_en = m_reg[31];
            if (w) begin
                if (m_reg[31] && d[21]) m_err = 1'b1;
                m_reg = model_wr(m_reg, d);
            end
            chk(rd_data == (m_reg | {31'b0, inv_busy}), "R2 random rd", rd_data,
                m_reg | {31'b0, inv_busy});
            chk(cfg_err == m_err && cache_en == m_en && wt_mode == m_reg[19]
                && alloc_lock == (m_reg[22] & m_reg[10]), "R4 random outs",
                {cfg_err, cache_en, wt_mode, alloc_lock},
                {m_err, m_en, m_reg[19], m_reg[22] & m_reg[10]});
        end
        wr_en = 1'b0;
        txn_accept = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule